// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block sits between three supply comparators and a small processor core. The comparators report that the supply is below the early-warning level, below the lowest level at which the core can run, or below the level where the backup cell has to take over. The block turns these flags into four kinds of control: a one-cycle warning interrupt request with a fixed vector, a reset hold for the core, a hold that keeps every memory chip enable and the read/write strobe at logic 1, and a battery-select output. After the supply comes back above the minimum level, the block keeps the core in reset for a counted power-on delay.

The flags are asynchronous, so each passes through a synchronizer first. The synchronized flags are then made consistent: a lower level always implies the levels above it. A state machine with five states follows them. ST_BROWNOUT holds reset with the supply still feeding the core. ST_BATTERY also selects the backup cell. ST_PORDELAY counts the power-on delay. ST_RUN is normal operation. ST_WARNED is normal operation below the warning level.

The transitions are as follows. Any state goes to ST_BATTERY on the battery flag. ST_RUN, ST_WARNED and ST_PORDELAY go to ST_BROWNOUT on the minimum flag. ST_BATTERY leaves for ST_BROWNOUT, or for ST_PORDELAY if the supply is already above the minimum. ST_BROWNOUT goes to ST_PORDELAY when the minimum flag clears. ST_PORDELAY goes to ST_RUN or ST_WARNED once the count completes. ST_RUN goes to ST_WARNED on the warning flag and raises the interrupt. ST_WARNED returns to ST_RUN when the warning flag clears. The external reset pin resets the block asynchronously into ST_BROWNOUT. While it is high, the synchronizers read "below minimum, not on battery", so a power-on delay always follows a pin reset.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: While `rst_pin` is 1, `cpu_reset` and `strobe_hold` are 1 at once (asynchronously), and `batt_sel` and `warn_irq` are 0.
- R2: When the warning flag goes from clear to set while the core runs and `warn_irq_en` is 1, `warn_irq` is 1 for exactly one cycle, and `irq_vector` reads 8'h2B.
- R3: Below the warning level but above the minimum level, `cpu_reset` stays 0, so the core keeps running.
- R4: The warning interrupt is edge-triggered. It does not fire again while the warning flag stays set, even if `warn_irq_en` is raised later. It is re-armed only after the flag clears.
- R5: When the minimum flag is set, `cpu_reset` and `strobe_hold` both become 1. `strobe_hold` = 1 means that all decoded chip enables and the read/write strobe must be driven to logic 1.
- R6: When the battery flag is set, `batt_sel` is 1 together with `cpu_reset`. `batt_sel` returns to 0 when the battery flag clears.
- R7: After the minimum flag clears, `cpu_reset` stays 1 for exactly POR_CYCLES (default 21504) cycles in ST_PORDELAY. It falls POR_CYCLES + SYNC_STAGES + 1 clock edges after the flag change.
- R8: A new dip below the minimum level during the power-on delay aborts the count. The full count restarts after the next recovery.
- R9: The flags are nested: a minimum flag without the warning flag acts as below-warning, and a battery flag acts as below-minimum.
- R10: If the delay completes while the supply is still below the warning level, the core is released with no warning interrupt, because the warning level was never re-crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | External reset, active high, asynchronous |
| vcc_below_warn | input | 1 | Comparator: supply below warning level |
| vcc_below_min | input | 1 | Comparator: supply below minimum operating level |
| vcc_below_batt | input | 1 | Comparator: supply below battery switchover level |
| warn_irq_en | input | 1 | Enable for the warning interrupt |
| cpu_reset | output | 1 | Holds the core in reset |
| strobe_hold | output | 1 | Forces chip enables and the read/write strobe to logic 1 |
| batt_sel | output | 1 | Selects the backup cell as supply source |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| irq_vector | output | 8 | Interrupt vector address, fixed at 8'h2B |

## Verification
Every flag change reaches the outputs on the third rising edge after it is driven: two synchronizer stages, then the state register. The interrupt pulse is registered on that same edge. The bench drives flags just after a falling edge and samples each result half a cycle after the edge on which it is due. It checks the value one edge earlier as well, so a result that arrives early or late is caught. The power-on release is checked by counting POR_CYCLES + 3 edges from the recovery and requiring `cpu_reset` to be 1 on every sample before the last edge and 0 after it. The asynchronous pin reset is sampled one time unit after it is driven.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_BROWNOUT = 3'd0,
        ST_BATTERY  = 3'd1,
        ST_PORDELAY = 3'd2,
        ST_RUN      = 3'd3,
        ST_WARNED   = 3'd4
    } pfs_state_e;

    localparam int LVL_WARN  = 0;
    localparam int LVL_MIN   = 1;
    localparam int LVL_BATT  = 2;
    localparam int NUM_LVLS  = 3;

    typedef struct packed {
        logic batt;
        logic min;
        logic warn;
    } supply_lvl_t;

endpackage

// File: rtl/pfs_flag_sync.sv
module pfs_flag_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    localparam int LAST = STAGES - 1;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d_in[b]};
                end
            end

            assign q_out[b] = chain[LAST];
        end
    endgenerate

endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
    parameter int CYCLES = 21504
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R7: the count never passes the programmed limit
    p_cnt_limit_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R8: leaving the delay state clears the count
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  supply_lvl_t lvl,
    input  logic        irq_en,
    input  logic        timer_done,
    output logic        timer_run,
    output logic        cpu_reset,
    output logic        strobe_hold,
    output logic        batt_sel,
    output logic        warn_irq
);

    pfs_state_e state, nxt;
    logic       irq_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_BROWNOUT;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BATTERY: begin
                if (!lvl.batt) begin
                    nxt = lvl.min ? ST_BROWNOUT : ST_PORDELAY;
                end
            end
            ST_BROWNOUT: begin
                if (lvl.batt)      nxt = ST_BATTERY;
                else if (!lvl.min) nxt = ST_PORDELAY;
            end
            ST_PORDELAY: begin
                if (lvl.batt)         nxt = ST_BATTERY;
                else if (lvl.min)     nxt = ST_BROWNOUT;
                else if (timer_done)  nxt = lvl.warn ? ST_WARNED : ST_RUN;
            end
            ST_RUN: begin
                if (lvl.batt)      nxt = ST_BATTERY;
                else if (lvl.min)  nxt = ST_BROWNOUT;
                else if (lvl.warn) nxt = ST_WARNED;
            end
            ST_WARNED: begin
                if (lvl.batt)      nxt = ST_BATTERY;
                else if (lvl.min)  nxt = ST_BROWNOUT;
                else if (!lvl.warn) nxt = ST_RUN;
            end
            default: nxt = ST_BROWNOUT;
        endcase
    end

    // Interrupt request: only on the RUN -> WARNED crossing
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (state == ST_RUN) && (nxt == ST_WARNED) && irq_en;
        end
    end

    always_comb begin
        timer_run   = 1'b0;
        cpu_reset   = 1'b1;
        strobe_hold = 1'b1;
        batt_sel    = 1'b0;
        unique case (state)
            ST_BATTERY: begin
                batt_sel = 1'b1;
            end
            ST_BROWNOUT: begin
                batt_sel = 1'b0;
            end
            ST_PORDELAY: begin
                timer_run = 1'b1;
            end
            ST_RUN, ST_WARNED: begin
                cpu_reset   = 1'b0;
                strobe_hold = 1'b0;
            end
            default: begin
                cpu_reset = 1'b1;
            end
        endcase
    end

    assign warn_irq = irq_q;

    // R2: the request lasts one cycle
    p_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
        warn_irq |=> !warn_irq);

    // R2: the request needs the enable on the crossing edge
    p_irq_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        warn_irq |-> $past(irq_en));

    // R3: the request only appears while the core runs
    p_irq_running_r3: assert property (@(posedge clk) disable iff (rst)
        warn_irq |-> !cpu_reset);

    // R6: battery select always comes with reset
    p_batt_reset_r6: assert property (@(posedge clk) disable iff (rst)
        batt_sel |-> (cpu_reset && strobe_hold));

    // R7: reset is released only by a completed count
    p_release_timed_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_reset) |-> $past(timer_done));

endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor
    import pfs_pkg::*;
#(
    parameter int         POR_CYCLES  = 21504,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] IRQ_VECTOR  = 8'h2B
) (
    input  logic       clk,
    input  logic       rst_pin,
    input  logic       vcc_below_warn,
    input  logic       vcc_below_min,
    input  logic       vcc_below_batt,
    input  logic       warn_irq_en,
    output logic       cpu_reset,
    output logic       strobe_hold,
    output logic       batt_sel,
    output logic       warn_irq,
    output logic [7:0] irq_vector
);

    localparam logic [NUM_LVLS-1:0] SYNC_RST = 3'b011;

    logic [NUM_LVLS-1:0] raw_lvl;
    logic [NUM_LVLS-1:0] syn_lvl;
    supply_lvl_t         lvl;
    logic                timer_run;
    logic                timer_done;

    assign raw_lvl[LVL_WARN] = vcc_below_warn;
    assign raw_lvl[LVL_MIN]  = vcc_below_min;
    assign raw_lvl[LVL_BATT] = vcc_below_batt;

    pfs_flag_sync #(
        .WIDTH   (NUM_LVLS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst   (rst_pin),
        .d_in  (raw_lvl),
        .q_out (syn_lvl)
    );

    // Nesting: each lower level implies every level above it
    assign lvl.batt = syn_lvl[LVL_BATT];
    assign lvl.min  = syn_lvl[LVL_MIN] | syn_lvl[LVL_BATT];
    assign lvl.warn = syn_lvl[LVL_WARN] | syn_lvl[LVL_MIN] | syn_lvl[LVL_BATT];

    pfs_por_timer #(
        .CYCLES (POR_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst  (rst_pin),
        .run  (timer_run),
        .done (timer_done)
    );

    pfs_fsm u_fsm (
        .clk         (clk),
        .rst         (rst_pin),
        .lvl         (lvl),
        .irq_en      (warn_irq_en),
        .timer_done  (timer_done),
        .timer_run   (timer_run),
        .cpu_reset   (cpu_reset),
        .strobe_hold (strobe_hold),
        .batt_sel    (batt_sel),
        .warn_irq    (warn_irq)
    );

    assign irq_vector = IRQ_VECTOR;

    // R5: a synchronized minimum flag forces reset and strobe hold next cycle
    p_min_forces_reset_r5: assert property (@(posedge clk) disable iff (rst_pin)
        lvl.min |=> (cpu_reset && strobe_hold));

    // R6: a synchronized battery flag selects the cell next cycle
    p_batt_follows_r6: assert property (@(posedge clk) disable iff (rst_pin)
        lvl.batt |=> batt_sel);

    // R9: minimum flag alone still counts as below warning
    p_nest_r9: assert property (@(posedge clk) disable iff (rst_pin)
        syn_lvl[LVL_MIN] |=> !warn_irq);

endmodule

// File: tb/sim_pwr_fail_supervisor.sv
module sim_pwr_fail_supervisor;

    localparam int POR  = 21504;
    localparam int LAT  = 3;

    logic       clk = 1'b0;
    logic       rst_pin;
    logic       b_warn, b_min, b_batt, ie;
    logic       cpu_reset, strobe_hold, batt_sel, warn_irq;
    logic [7:0] irq_vector;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pwr_fail_supervisor u0 (
        .clk            (clk),
        .rst_pin        (rst_pin),
        .vcc_below_warn (b_warn),
        .vcc_below_min  (b_min),
        .vcc_below_batt (b_batt),
        .warn_irq_en    (ie),
        .cpu_reset      (cpu_reset),
        .strobe_hold    (strobe_hold),
        .batt_sel       (batt_sel),
        .warn_irq       (warn_irq),
        .irq_vector     (irq_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_lvl(input logic w, input logic m, input logic b);
        b_warn = w;
        b_min  = m;
        b_batt = b;
    endtask

    function automatic bit exp_irq(input bit prev_w, input bit now_w, input bit en, input int c);
        return (c == LAT) && !prev_w && now_w && en;
    endfunction

    // R7: reset must hold until exactly POR+LAT edges after recovery
    task automatic expect_delay(input string tag);
        int  bad_at = -1;
        bit  irq_seen = 1'b0;
        for (int k = 1; k <= POR + LAT; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (warn_irq) irq_seen = 1'b1;
            if ((cpu_reset !== (k < POR + LAT)) && bad_at < 0) bad_at = k;
        end
        check(bad_at < 0, tag, bad_at, 0);
        check(!irq_seen, "R10 no irq during delay", int'(irq_seen), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_pin = 1'b1;
        set_lvl(1'b0, 1'b0, 1'b0);
        ie = 1'b0;
        tick(5);

        // R1: reset state
        check(cpu_reset === 1'b1, "R1 cpu_reset in reset", int'(cpu_reset), 1);
        check(strobe_hold === 1'b1, "R1 strobe_hold in reset", int'(strobe_hold), 1);
        check(batt_sel === 1'b0 && warn_irq === 1'b0, "R1 batt/irq in reset",
              int'({batt_sel, warn_irq}), 0);

        rst_pin = 1'b0;
        expect_delay("R7 delay after pin release");

        // R4: enable raised while already below warning gives no request
        ie = 1'b0;
        set_lvl(1'b1, 1'b0, 1'b0);
        tick(5);
        ie = 1'b1;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                tick(1);
                if (warn_irq) seen = 1'b1;
            end
            check(!seen, "R4 no late irq", int'(seen), 0);
        end
        set_lvl(1'b0, 1'b0, 1'b0);
        tick(5);
        set_lvl(1'b1, 1'b0, 1'b0);
        tick(LAT - 1);
        check(warn_irq === 1'b0, "R2 irq not early", int'(warn_irq), 0);
        tick(1);
        check(warn_irq === 1'b1, "R4 re-armed irq", int'(warn_irq), 1);
        check(irq_vector === 8'h2B, "R2 vector", int'(irq_vector), 'h2B);
        tick(1);
        check(warn_irq === 1'b0, "R2 single pulse", int'(warn_irq), 0);

        // R2 R3: random warning crossings
        begin
            bit prev = 1'b1;
            for (int s = 0; s < 60; s++) begin
                bit nl  = 1'($urandom % 2);
                bit en  = 1'($urandom % 2);
                int h   = 4 + int'($urandom % 4);
                int bad = 0;
                int act = 0;
                ie = en;
                set_lvl(nl, 1'b0, 1'b0);
                for (int c = 1; c <= h; c++) begin
                    tick(1);
                    if (warn_irq !== exp_irq(prev, nl, en, c)) begin
                        bad = c;
                        act = int'(warn_irq);
                    end
                    if (cpu_reset !== 1'b0) begin
                        bad = 100 + c;
                        act = int'(cpu_reset);
                    end
                end
                check(bad == 0, "R2 R3 random step", act, bad);
                prev = nl;
            end
        end

        // R5 R8: dip below minimum, then a dip inside the delay
        set_lvl(1'b1, 1'b1, 1'b0);
        tick(LAT - 1);
        check(cpu_reset === 1'b0, "R5 reset not early", int'(cpu_reset), 0);
        tick(1);
        check(cpu_reset === 1'b1 && strobe_hold === 1'b1, "R5 reset and strobe hold",
              int'({cpu_reset, strobe_hold}), 3);
        set_lvl(1'b0, 1'b0, 1'b0);
        tick(1000);
        check(cpu_reset === 1'b1, "R8 mid delay", int'(cpu_reset), 1);
        set_lvl(1'b1, 1'b1, 1'b0);
        tick(6);
        set_lvl(1'b0, 1'b0, 1'b0);
        expect_delay("R8 restarted delay");

        // R9: minimum flag without warning flag
        set_lvl(1'b0, 1'b1, 1'b0);
        tick(LAT);
        check(cpu_reset === 1'b1, "R9 min alone resets", int'(cpu_reset), 1);
        // R10: recover only to below-warning
        set_lvl(1'b1, 1'b0, 1'b0);
        ie = 1'b1;
        expect_delay("R10 delay into warning region");
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 6; i++) begin
                tick(1);
                if (warn_irq) seen = 1'b1;
            end
            check(!seen && cpu_reset === 1'b0, "R10 released silently",
                  int'({seen, cpu_reset}), 0);
        end

        // R6: battery level
        set_lvl(1'b1, 1'b1, 1'b1);
        tick(LAT - 1);
        check(batt_sel === 1'b0, "R6 batt not early", int'(batt_sel), 0);
        tick(1);
        check(batt_sel === 1'b1 && cpu_reset === 1'b1, "R6 battery selected",
              int'({batt_sel, cpu_reset}), 3);
        set_lvl(1'b1, 1'b1, 1'b0);
        tick(LAT);
        check(batt_sel === 1'b0 && cpu_reset === 1'b1, "R6 back to supply",
              int'({batt_sel, cpu_reset}), 1);
        set_lvl(1'b0, 1'b0, 1'b0);
        expect_delay("R7 delay after battery");

        // R1: pin reset while running
        rst_pin = 1'b1;
        #1;
        check(cpu_reset === 1'b1 && strobe_hold === 1'b1, "R1 async pin reset",
              int'({cpu_reset, strobe_hold}), 3);
        tick(3);
        rst_pin = 1'b0;
        expect_delay("R7 delay after second pin reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule